// File: doc/BRIEF.md
# PCCC Turbo Encoder (Unterminated, Punctured)

This block is a rate-1/3 parallel concatenated convolutional encoder that handles one information block at a time. It takes in a block of serial information bits whose length is set per block. It stores the block internally. Once the last bit has arrived, it emits one output triple for each information bit. A triple holds the systematic bit, a parity bit from a constituent encoder that reads the block in natural order, and a parity bit from an identical encoder that reads the block in permuted order.

The permutation is not built into the block. For each output index the encoder drives that index on an address port. An external source answers in the same cycle with the position of the block bit that feeds the second encoder. The trellises are never terminated: both encoders start from the all-zero state at the start of every block and simply stop after the final bit, with no tail bits. A keep mask travels with each triple. It marks which of the three bits survive puncturing for the selected code rate. The output uses a valid/ready handshake and flags the final triple of the block.

Top module: `pccc_encoder`

## Requirements
- R1: After a synchronous active-low reset, and after a reset applied in the middle of a block, out_valid is 0, out_last is 0 and in_ready is 1.
- R2: in_ready stays 1 until the block length in bits has been accepted. It then falls, and out_valid rises in the next cycle. in_ready and out_valid are never 1 together.
- R3: Bit 2 of out_data on triple k equals the k-th accepted information bit of the block.
- R4: Bit 1 of out_data is the parity of a recursive systematic encoder with 3 state bits, feedback 1+D^2+D^3 and feedforward 1+D+D^3. It is fed the block in natural order and starts from the all-zero state in every block.
- R5: During triple k, perm_idx equals k. Bit 0 of out_data is the parity of an identical encoder, also starting from zero, fed with the stored bit at position perm_addr.
- R6: No tail is added: exactly one triple is produced per information bit. out_last is 1 only on the final triple, and after it is taken the block returns to accepting input.
- R7: The length and rate inputs are sampled with the first bit of a block, and later changes during that block are ignored. Lengths below 32 are treated as 32 and lengths above 432 as 432.
- R8: out_keep uses the same bit order as out_data and resets its phase k at the start of each block. Rate code 0 (1/3) keeps 111. Code 1 (1/2) keeps 110 for even k and 101 for odd k. Code 2 (2/3) keeps 110 for even k and 100 for odd k. Code 3 (3/4) keeps 110 when k mod 3 is 0 and 100 otherwise.
- R9: While out_valid is 1 and out_ready is 0, the triple, keep mask, last flag and perm_idx hold, and neither encoder advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_len | input | 9 | Block length in bits, sampled with the first bit |
| cfg_rate | input | 2 | Rate code: 0=1/3, 1=1/2, 2=2/3, 3=3/4 |
| in_valid | input | 1 | Information bit offered |
| in_ready | output | 1 | Block is accepting information bits |
| in_bit | input | 1 | Information bit |
| perm_idx | output | 9 | Output index for which a permuted address is requested |
| perm_addr | input | 9 | Permuted position for perm_idx, same cycle |
| out_valid | output | 1 | Output triple available |
| out_ready | input | 1 | Consumer takes the triple |
| out_data | output | 3 | {systematic, natural parity, permuted parity} |
| out_keep | output | 3 | Puncturing keep mask, same bit order |
| out_last | output | 1 | Final triple of the block |

## Verification
Both constituent encoders are recursive and are never flushed. A single wrong state bit therefore keeps corrupting the affected parity stream from the triple where it enters until the end of the block, so a model mismatch shows within one triple and never heals. A corrupted stored bit shows up in the systematic bit at its own index, and in the permuted parity at the first index whose address points to it. A slipped puncturing phase changes out_keep on the next triple. A wrong count only shows at the block edge, as a missing, early or extra last flag. That is why the bench compares every triple of every block and checks the idle state right after each last flag.

// File: rtl/pccc_pkg.sv
// Package: shared types and the puncturing rule for the PCCC encoder.
package pccc_pkg;

    typedef enum logic [1:0] {
        RATE_1_3 = 2'd0,
        RATE_1_2 = 2'd1,
        RATE_2_3 = 2'd2,
        RATE_3_4 = 2'd3
    } rate_e;

    typedef enum logic {
        PH_LOAD = 1'b0,
        PH_EMIT = 1'b1
    } phase_e;

    // Keep mask, bit order {sys, natural parity, permuted parity}.
    function automatic logic [2:0] keep_mask(input rate_e r, input logic [1:0] ph);
        logic [2:0] m;
        case (r)
            RATE_1_3: m = 3'b111;
            RATE_1_2: m = ph[0] ? 3'b101 : 3'b110;
            RATE_2_3: m = ph[0] ? 3'b100 : 3'b110;
            default:  m = (ph == 2'd0) ? 3'b110 : 3'b100;
        endcase
        return m;
    endfunction

    // Last puncturing phase before wrap for a rate.
    function automatic logic [1:0] last_phase(input rate_e r);
        return (r == RATE_3_4) ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/pccc_rsc_enc.sv
// Recursive systematic constituent encoder.
// Emits the parity of the current input combinationally; state moves on step.
// Assumes clear and step are never asserted together (clear wins if they are).
module pccc_rsc_enc #(
    parameter int          REGS    = 3,
    parameter logic [2:0]  FB_TAPS = 3'b110,  // bit i = tap on D^(i+1): D^2, D^3
    parameter logic [2:0]  FF_TAPS = 3'b101   // D, D^3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic u,
    output logic parity
);
    logic [REGS-1:0] state;
    logic            fb_bit;

    // Feedback and parity of the current input.
    always_comb begin
        fb_bit = u ^ (^(state & FB_TAPS[REGS-1:0]));
        parity = fb_bit ^ (^(state & FF_TAPS[REGS-1:0]));
    end

    // Shift register: zeroed by reset or clear, shifts on step.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            state <= '0;
        end else if (step) begin
            state <= {state[REGS-2:0], fb_bit};
        end
    end
endmodule

// File: rtl/pccc_bit_store.sv
// Block buffer: one register per information bit, one write port and two
// read ports (natural and permuted order).
// Assumes readers ignore data at indices not written in the current block.
module pccc_bit_store #(
    parameter  int DEPTH = 432,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_bit,
    input  logic [IDX_W-1:0] rd_idx_a,
    output logic             rd_bit_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output logic             rd_bit_b
);
    logic [DEPTH-1:0] cells;

    // Write the incoming bit; data cells carry no reset.
    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_idx) < DEPTH)) begin
            cells[wr_idx] <= wr_bit;
        end
    end

    // Guarded reads; out-of-range addresses read as zero.
    always_comb begin
        rd_bit_a = (int'(rd_idx_a) < DEPTH) ? cells[rd_idx_a] : 1'b0;
        rd_bit_b = (int'(rd_idx_b) < DEPTH) ? cells[rd_idx_b] : 1'b0;
    end
endmodule

// File: rtl/pccc_puncture.sv
// Puncturing phase tracker: gives the keep mask of the current triple.
// Assumes rate is constant for the whole block.
module pccc_puncture
    import pccc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       step,
    input  rate_e      rate,
    output logic [2:0] keep
);
    logic [1:0] ph;

    // Phase counter wraps at the rate's period.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ph <= 2'd0;
        end else if (step) begin
            ph <= (ph == last_phase(rate)) ? 2'd0 : ph + 2'd1;
        end
    end

    // Mask lookup.
    always_comb keep = keep_mask(rate, ph);
endmodule

// File: rtl/pccc_encoder.sv
// Rate-1/3 parallel concatenated convolutional encoder with puncturing mask.
// Loads a full block, then emits one {sys, p_nat, p_perm} triple per bit.
// Assumes perm_addr answers perm_idx combinationally with a position < length.
// Trellises are left unterminated; both encoders restart at zero each block.
module pccc_encoder
    import pccc_pkg::*;
#(
    parameter  int MAX_LEN = 432,
    parameter  int MIN_LEN = 32,
    localparam int LEN_W   = $clog2(MAX_LEN + 1),
    localparam int IDX_W   = $clog2(MAX_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [1:0]       cfg_rate,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_bit,
    output logic [IDX_W-1:0] perm_idx,
    input  logic [IDX_W-1:0] perm_addr,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [2:0]       out_data,
    output logic [2:0]       out_keep,
    output logic             out_last
);
    localparam int N_ENC = 2;

    phase_e           phase;
    logic [IDX_W-1:0] cnt;
    logic [LEN_W-1:0] len_q;
    rate_e            rate_q;
    logic [LEN_W-1:0] len_clamped;
    logic [LEN_W-1:0] cur_len;
    logic [IDX_W-1:0] in_last_idx;
    logic [IDX_W-1:0] out_last_idx;
    logic             in_fire, in_end, out_fire, out_end;
    logic             sys_bit, perm_bit;
    logic [N_ENC-1:0] enc_u, enc_p;

    // Clamp the requested length into the supported range.
    always_comb begin
        if (cfg_len < LEN_W'(MIN_LEN))      len_clamped = LEN_W'(MIN_LEN);
        else if (cfg_len > LEN_W'(MAX_LEN)) len_clamped = LEN_W'(MAX_LEN);
        else                                len_clamped = cfg_len;
    end

    // Handshake and end-of-phase decode.
    always_comb begin
        cur_len      = (cnt == '0) ? len_clamped : len_q;
        in_last_idx  = IDX_W'(cur_len - LEN_W'(1));
        out_last_idx = IDX_W'(len_q - LEN_W'(1));
        in_ready     = (phase == PH_LOAD);
        out_valid    = (phase == PH_EMIT);
        in_fire      = in_valid && in_ready;
        in_end       = in_fire && (cnt == in_last_idx);
        out_fire     = out_valid && out_ready;
        out_end      = out_fire && (cnt == out_last_idx);
        out_last     = out_valid && (cnt == out_last_idx);
        perm_idx     = cnt;
    end

    // Phase, index counter and per-block configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_LOAD;
            cnt    <= '0;
            len_q  <= LEN_W'(MIN_LEN);
            rate_q <= RATE_1_3;
        end else begin
            case (phase)
                PH_LOAD: if (in_fire) begin
                    if (cnt == '0) begin
                        len_q  <= len_clamped;
                        rate_q <= rate_e'(cfg_rate);
                    end
                    if (in_end) begin
                        phase <= PH_EMIT;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_EMIT: if (out_fire) begin
                    if (out_end) begin
                        phase <= PH_LOAD;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_LOAD;
            endcase
        end
    end

    pccc_bit_store #(.DEPTH(MAX_LEN)) u_store (
        .clk      (clk),
        .wr_en    (in_fire),
        .wr_idx   (cnt),
        .wr_bit   (in_bit),
        .rd_idx_a (cnt),
        .rd_bit_a (sys_bit),
        .rd_idx_b (perm_addr),
        .rd_bit_b (perm_bit)
    );

    // Input selection for the natural (0) and permuted (1) encoders.
    always_comb enc_u = {perm_bit, sys_bit};

    for (genvar e = 0; e < N_ENC; e++) begin : g_enc
        pccc_rsc_enc u_rsc (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (in_end),
            .step   (out_fire),
            .u      (enc_u[e]),
            .parity (enc_p[e])
        );
    end

    pccc_puncture u_punct (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (in_end),
        .step  (out_fire),
        .rate  (rate_q),
        .keep  (out_keep)
    );

    // Output triple.
    always_comb out_data = {sys_bit, enc_p[0], enc_p[1]};
endmodule

// File: rtl/pccc_encoder_chk.sv
// Protocol checker for pccc_encoder, attached by bind.
module pccc_encoder_chk #(
    parameter int IDX_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [2:0]       out_data,
    input logic [2:0]       out_keep,
    input logic             out_last,
    input logic [IDX_W-1:0] perm_idx
);
    a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

    a_r5_first_index: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (perm_idx == '0));

    a_r5_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=> (perm_idx == $past(perm_idx) + 1'b1));

    a_r6_more_after: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=> out_valid);

    a_r6_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));

    a_r8_sys_always_kept: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_keep[2]);

    a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(perm_idx) &&
            $stable(out_data[2:1]) && $stable(out_keep) && $stable(out_last)));
endmodule

bind pccc_encoder pccc_encoder_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_keep  (out_keep),
    .out_last  (out_last),
    .perm_idx  (perm_idx)
);

// File: tb/test_pccc_encoder.sv
module test_pccc_encoder;
    localparam int MAX_LEN = 432;
    localparam int W = 9;
    localparam int NV = 7;
    // {length, rate, perm mode, seed, expected kept bits, stall index}
    localparam int VEC [NV][6] = '{
        '{ 32, 0, 0, 16'h0001,  96, -1},
        '{ 40, 1, 1, 16'hACE1,  80,  7},
        '{ 57, 2, 2, 16'h3C5A,  86, -1},
        '{432, 3, 2, 16'h1234, 576, 200},
        '{100, 3, 1, 16'h0F0F, 134, -1},
        '{ 33, 2, 0, 16'hBEEF,  50,  0},
        '{200, 1, 2, 16'h5555, 400, -1}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         rst_n;
    logic [W-1:0] cfg_len;
    logic [1:0]   cfg_rate;
    logic         in_valid, in_ready, in_bit;
    logic [W-1:0] perm_idx, perm_addr;
    logic         out_valid, out_ready, out_last;
    logic [2:0]   out_data, out_keep;

    int  n_cmp = 0, n_bad = 0;
    bit  done = 1'b0;
    bit  bits [MAX_LEN];
    int  pmode = 0, plen = 32;

    pccc_encoder i_pccc_encoder (
        .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_rate(cfg_rate),
        .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
        .perm_idx(perm_idx), .perm_addr(perm_addr),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_keep(out_keep), .out_last(out_last)
    );

    function automatic int perm_of(int k, int mode, int len);
        if (k >= len) return 0;
        case (mode)
            0:       return k;
            1:       return len - 1 - k;
            default: return (k * 5 + 3) % len;
        endcase
    endfunction

    always_comb perm_addr = W'(perm_of(int'(perm_idx), pmode, plen));

    function automatic int clamp_len(int l);
        if (l < 32)  return 32;
        if (l > 432) return 432;
        return l;
    endfunction

    function automatic logic [2:0] exp_keep(int rate, int k);
        case (rate)
            0:       return 3'b111;
            1:       return (k % 2 == 0) ? 3'b110 : 3'b101;
            2:       return (k % 2 == 0) ? 3'b110 : 3'b100;
            default: return (k % 3 == 0) ? 3'b110 : 3'b100;
        endcase
    endfunction

    // Returns {parity, next state}; st[0]=D^1, st[1]=D^2, st[2]=D^3.
    function automatic logic [3:0] rsc(logic [2:0] st, logic u);
        logic a, p;
        a = u ^ st[1] ^ st[2];
        p = a ^ st[0] ^ st[2];
        return {p, st[1], st[0], a};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Feed one block; leaves the bench at the negedge where triple 0 is shown.
    task automatic load_block(int cfg_l, int rate, int mode, int seed, bit chg);
        logic [15:0] lfsr;
        int n;
        n = clamp_len(cfg_l);
        lfsr = seed[15:0];
        for (int i = 0; i < n; i++) begin
            bits[i] = lfsr[0];
            lfsr = lfsr[0] ? ((lfsr >> 1) ^ 16'hB400) : (lfsr >> 1);
        end
        pmode = mode;
        plen = n;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 0) begin
                cfg_len = W'(cfg_l);
                cfg_rate = 2'(rate);
            end
            if (chg && i == 1) begin
                cfg_len = W'(n + 20);
                cfg_rate = ~2'(rate);
            end
            check(in_ready === 1'b1, "R2 ready during load", int'(in_ready), 1);
            in_valid = 1'b1;
            in_bit = bits[i];
        end
        @(negedge clk);
        in_valid = 1'b0;
        check(in_ready === 1'b0, "R2 ready after load", int'(in_ready), 0);
        check(out_valid === 1'b1, "R2 valid after load", int'(out_valid), 1);
    endtask

    task automatic emit_block(int n, int rate, int stall_at, output int kept);
        logic [2:0] st1, st2;
        logic [3:0] r1, r2;
        logic [2:0] snap;
        int a2;
        st1 = '0;
        st2 = '0;
        kept = 0;
        for (int k = 0; k < n; k++) begin
            if (k > 0) @(negedge clk);
            r1 = rsc(st1, bits[k]);
            a2 = perm_of(k, pmode, n);
            r2 = rsc(st2, bits[a2]);
            if (k == stall_at) begin
                out_ready = 1'b0;
                snap = out_data;
                repeat (3) @(negedge clk);
                check(out_valid === 1'b1 && out_data === snap, "R9 stall hold",
                      int'(out_data), int'(snap));
                out_ready = 1'b1;
            end
            check(out_valid === 1'b1, "R2 valid in emit", int'(out_valid), 1);
            check(int'(perm_idx) == k, "R5 perm_idx", int'(perm_idx), k);
            check(out_data[2] === bits[k], "R3 systematic", int'(out_data[2]), int'(bits[k]));
            check(out_data[1] === r1[3], "R4 natural parity", int'(out_data[1]), int'(r1[3]));
            check(out_data[0] === r2[3], "R5 permuted parity", int'(out_data[0]), int'(r2[3]));
            check(out_keep === exp_keep(rate, k), "R8 keep mask",
                  int'(out_keep), int'(exp_keep(rate, k)));
            check(out_last === (k == n - 1), "R6 last flag", int'(out_last), int'(k == n - 1));
            kept += $countones(out_keep);
            st1 = r1[2:0];
            st2 = r2[2:0];
        end
        @(negedge clk);
        check(out_valid === 1'b0 && in_ready === 1'b1, "R6 idle after last",
              int'({out_valid, in_ready}), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int kept;
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_bit = 1'b0;
        cfg_len = W'(32);
        cfg_rate = 2'd0;
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset
        check(in_ready === 1'b1, "R1 ready after reset", int'(in_ready), 1);
        check(out_valid === 1'b0, "R1 valid after reset", int'(out_valid), 0);
        check(out_last === 1'b0, "R1 last after reset", int'(out_last), 0);

        // Vector table: R2..R6, R8, R9
        for (int v = 0; v < NV; v++) begin
            load_block(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 1'b0);
            emit_block(clamp_len(VEC[v][0]), VEC[v][1], VEC[v][5], kept);
            check(kept == VEC[v][4], "R8 kept bit total", kept, VEC[v][4]);
        end

        // R7: short length clamps up to 32
        load_block(5, 1, 2, 16'h7777, 1'b0);
        emit_block(32, 1, -1, kept);
        check(kept == 64, "R7 clamp low", kept, 64);

        // R7: long length clamps down to 432
        load_block(500, 0, 1, 16'h4321, 1'b0);
        emit_block(432, 0, -1, kept);
        check(kept == 1296, "R7 clamp high", kept, 1296);

        // R7: configuration changes during a block are ignored
        load_block(48, 2, 2, 16'h2468, 1'b1);
        emit_block(48, 2, -1, kept);
        check(kept == 72, "R7 config held", kept, 72);

        // R1: reset in the middle of emitting a block
        load_block(64, 0, 0, 16'h1357, 1'b0);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(out_valid === 1'b0, "R1 valid after mid reset", int'(out_valid), 0);
        check(in_ready === 1'b1, "R1 ready after mid reset", int'(in_ready), 1);

        // R4/R5: encoders restart from zero after the aborted block
        load_block(35, 3, 2, 16'hCAFE, 1'b0);
        emit_block(35, 3, 10, kept);
        check(kept == 47, "R8 after reset", kept, 47);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule